// File: doc/BRIEF.md
# Dual-Channel PWM Slice Counter

This block is one pulse-width modulation slice: a single up-counter shared by two compare channels. Each channel drives its own output. An output stays high while the counter is below that channel's compare value, and each output has its own inversion control. Counting advances on a tick strobe that an external clock divider supplies, and only while the slice is enabled.

The counter runs in one of two modes. In trailing-edge mode it climbs to a period limit and then drops to zero. In phase-correct mode it climbs to the limit and then walks back down to zero, which halves the output frequency and centres the pulses. The period limit and both compare values are written into shadow registers. While the slice runs, they become active only at the period boundary, so a period is never torn. While the slice is stopped, they become active on the following cycle.

Software can also do three other things:
- load the counter directly;
- request a single-count phase advance, which works even while the slice is stopped;
- request a single-count phase retard.

Each boundary gives a one-cycle wrap pulse, which can pace a DMA engine. The same boundary sets a sticky interrupt flag.

Top module: `pwm_slice`

## Requirements
- R1: In trailing-edge mode (`phase_correct`=0), each effective step moves the counter up by one. A step taken at or above the active limit goes to 0 instead, and that step is a period boundary.
- R2: In phase-correct mode (`phase_correct`=1), the counter climbs to the active limit and then counts down one per step. The step that lands on 0 is a period boundary and turns the counter upward again. With a limit of 0, every step is a boundary at count 0.
- R3: A channel's uninverted level is registered. On each cycle where the slice is enabled or takes a step, it becomes 1 if the counter was below the active compare value, and 0 otherwise. A compare value of 0 therefore keeps the output low.
- R4: While `en`=1, written limit and compare values stay in shadow storage. They become active on the cycle after the next period boundary step.
- R5: While `en`=0, the following hold:
  - shadow values become active one cycle after they are written;
  - the counter does not move without an advance request;
  - the outputs keep their levels.
  When `en` returns to 1, counting resumes from the held value.
- R6: A pulse on `adv_req` sets `adv_busy`. The counter then takes one extra step on the first cycle without an enabled tick, and `adv_busy` clears. A pulse on `ret_req` sets `ret_busy`. The next enabled tick is swallowed without a step, and `ret_busy` clears.
- R7: `inv_a` and `inv_b` each invert their channel's output directly, with no added delay.
- R8: After reset:
  - the counter is 0;
  - the active limit is all ones (0xFFFF at the default width);
  - both compare values are 0;
  - both registered levels are 0;
  - no requests are pending;
  - `wrap_pulse` and `irq_raw` are 0.
- R9: A boundary step raises `wrap_pulse` for exactly the next cycle, with the counter then at 0. The same step sets `irq_raw`, which stays set until a cycle with `irq_clr`=1 and no new boundary.
- R10: `ctr_wr` loads `ctr_wdata` into the counter on the next edge. It takes priority over any step in that cycle and leaves pending requests pending.
- R11: With a limit of 0, a counter of 0 and a compare of 0, one enabled cycle drives the channel low. A compare of 1 drives it high instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Slice run enable |
| tick | input | 1 | Count strobe from the clock divider |
| phase_correct | input | 1 | 1 selects up/down counting |
| inv_a | input | 1 | Invert channel A output |
| inv_b | input | 1 | Invert channel B output |
| top_wr | input | 1 | Write strobe for the period limit |
| top_wdata | input | CNT_W | New period limit |
| cmp_a_wr | input | 1 | Write strobe for compare A |
| cmp_a_wdata | input | CNT_W | New compare A value |
| cmp_b_wr | input | 1 | Write strobe for compare B |
| cmp_b_wdata | input | CNT_W | New compare B value |
| ctr_wr | input | 1 | Counter load strobe |
| ctr_wdata | input | CNT_W | Counter load value |
| adv_req | input | 1 | Phase advance request pulse |
| ret_req | input | 1 | Phase retard request pulse |
| irq_clr | input | 1 | Clears the sticky interrupt flag |
| count | output | CNT_W | Current counter value |
| out_a | output | 1 | Channel A output |
| out_b | output | 1 | Channel B output |
| wrap_pulse | output | 1 | One-cycle period boundary pulse |
| irq_raw | output | 1 | Sticky boundary interrupt flag |
| adv_busy | output | 1 | Advance request pending |
| ret_busy | output | 1 | Retard request pending |

## Verification
The assertions check the following on every cycle:
- the counter holding while stopped;
- the unit up-step in trailing-edge mode;
- a counter of zero under every wrap pulse;
- the stickiness of the interrupt flag;
- the self-clearing of both phase requests;
- active limits changing only at boundaries or while stopped.

Several behaviours need the bench's scenarios, which sweep limits, compare values, modes and tick patterns against an arithmetic model of the slice. These behaviours are:
- the exact phase-correct turnaround sequence;
- the one-cycle lag of the channel levels;
- the timing of deferred compare updates;
- the hold-then-force trick for parking outputs.

// File: rtl/pwm_slice_pkg.sv
package pwm_slice_pkg;
   typedef enum logic {
      DIR_UP   = 1'b0,
      DIR_DOWN = 1'b1
   } cnt_dir_e;

   localparam int unsigned PWM_NCH = 2;
endpackage

// File: rtl/pwm_dbuf.sv
module pwm_dbuf #(
   parameter int unsigned W   = 16,
   parameter logic [W-1:0] RST = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   input  logic         load,
   output logic [W-1:0] act
);
   logic [W-1:0] shadow_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow_q <= RST;
         act      <= RST;
      end else begin
         if (wr)   shadow_q <= wdata;
         if (load) act      <= shadow_q;
      end
   end
endmodule

// File: rtl/pwm_slice_core.sv
module pwm_slice_core
   import pwm_slice_pkg::*;
#(
   parameter int unsigned CNT_W = 16,
   parameter bit          PC_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             tick,
   input  logic             pc_mode,
   input  logic             ctr_wr,
   input  logic [CNT_W-1:0] ctr_wdata,
   input  logic             adv_req,
   input  logic             ret_req,
   input  logic             irq_clr,
   input  logic [CNT_W-1:0] top_act,
   output logic [CNT_W-1:0] cnt,
   output logic             step,
   output logic             bnd_step,
   output logic             wrap_pulse,
   output logic             irq_raw,
   output logic             adv_busy,
   output logic             ret_busy
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   cnt_dir_e         dir_q, dir_n;
   logic [CNT_W-1:0] nxt;
   logic             bnd;
   logic             pc_eff;
   logic             tick_en;
   logic             adv_do, ret_do;

   if (PC_EN) begin : g_pc
      assign pc_eff = pc_mode;
   end else begin : g_no_pc
      assign pc_eff = 1'b0;
   end

   assign tick_en  = en & tick;
   assign ret_do   = ret_busy & tick_en & ~ctr_wr;
   assign adv_do   = adv_busy & ~tick_en & ~ctr_wr;
   assign step     = ~ctr_wr & ((tick_en & ~ret_busy) | adv_do);
   assign bnd_step = step & bnd;

   always_comb begin
      nxt   = cnt;
      dir_n = dir_q;
      bnd   = 1'b0;
      if (!pc_eff) begin
         dir_n = DIR_UP;
         if (cnt >= top_act) begin
            nxt = '0;
            bnd = 1'b1;
         end else begin
            nxt = cnt + ONE;
         end
      end else if (dir_q == DIR_UP && cnt < top_act) begin
         nxt = cnt + ONE;
      end else if (cnt == '0) begin
         nxt   = '0;
         bnd   = 1'b1;
         dir_n = DIR_UP;
      end else begin
         nxt   = cnt - ONE;
         bnd   = (cnt == ONE);
         dir_n = (cnt == ONE) ? DIR_UP : DIR_DOWN;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt        <= '0;
         dir_q      <= DIR_UP;
         wrap_pulse <= 1'b0;
         irq_raw    <= 1'b0;
         adv_busy   <= 1'b0;
         ret_busy   <= 1'b0;
      end else begin
         if (ctr_wr) begin
            cnt <= ctr_wdata;
         end else if (step) begin
            cnt   <= nxt;
            dir_q <= dir_n;
         end
         wrap_pulse <= bnd_step;
         irq_raw    <= (irq_raw & ~irq_clr) | bnd_step;
         adv_busy   <= (adv_busy & ~adv_do) | adv_req;
         ret_busy   <= (ret_busy & ~ret_do) | ret_req;
      end
   end
endmodule

// File: rtl/pwm_chan_out.sv
module pwm_chan_out #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             upd,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] cmp_act,
   input  logic             inv,
   output logic             pin
);
   logic lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   lvl_q <= 1'b0;
      else if (upd) lvl_q <= (cnt < cmp_act);
   end

   assign pin = lvl_q ^ inv;
endmodule

// File: rtl/pwm_slice.sv
module pwm_slice
   import pwm_slice_pkg::*;
#(
   parameter int unsigned CNT_W = 16,
   parameter bit          PC_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             tick,
   input  logic             phase_correct,
   input  logic             inv_a,
   input  logic             inv_b,
   input  logic             top_wr,
   input  logic [CNT_W-1:0] top_wdata,
   input  logic             cmp_a_wr,
   input  logic [CNT_W-1:0] cmp_a_wdata,
   input  logic             cmp_b_wr,
   input  logic [CNT_W-1:0] cmp_b_wdata,
   input  logic             ctr_wr,
   input  logic [CNT_W-1:0] ctr_wdata,
   input  logic             adv_req,
   input  logic             ret_req,
   input  logic             irq_clr,
   output logic [CNT_W-1:0] count,
   output logic             out_a,
   output logic             out_b,
   output logic             wrap_pulse,
   output logic             irq_raw,
   output logic             adv_busy,
   output logic             ret_busy
);
   localparam logic [CNT_W-1:0] TOP_RST = {CNT_W{1'b1}};

   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
      $error("pwm_slice: CNT_W must be in 2..32");
   end

   logic             step, bnd_step, upd, load;
   logic [CNT_W-1:0] top_act;
   logic             ch_wr   [PWM_NCH];
   logic [CNT_W-1:0] ch_wd   [PWM_NCH];
   logic             ch_inv  [PWM_NCH];
   logic             ch_pin  [PWM_NCH];
   logic [CNT_W-1:0] cmp_act [PWM_NCH];

   assign ch_wr[0]  = cmp_a_wr;
   assign ch_wr[1]  = cmp_b_wr;
   assign ch_wd[0]  = cmp_a_wdata;
   assign ch_wd[1]  = cmp_b_wdata;
   assign ch_inv[0] = inv_a;
   assign ch_inv[1] = inv_b;
   assign out_a     = ch_pin[0];
   assign out_b     = ch_pin[1];

   assign upd  = en | step;
   assign load = ~en | bnd_step;

   pwm_slice_core #(.CNT_W(CNT_W), .PC_EN(PC_EN)) u_core (
      .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .pc_mode(phase_correct),
      .ctr_wr(ctr_wr), .ctr_wdata(ctr_wdata), .adv_req(adv_req), .ret_req(ret_req),
      .irq_clr(irq_clr), .top_act(top_act), .cnt(count), .step(step),
      .bnd_step(bnd_step), .wrap_pulse(wrap_pulse), .irq_raw(irq_raw),
      .adv_busy(adv_busy), .ret_busy(ret_busy)
   );

   pwm_dbuf #(.W(CNT_W), .RST(TOP_RST)) u_top_buf (
      .clk(clk), .rst_n(rst_n), .wr(top_wr), .wdata(top_wdata),
      .load(load), .act(top_act)
   );

   for (genvar c = 0; c < PWM_NCH; c++) begin : g_ch
      pwm_dbuf #(.W(CNT_W), .RST('0)) u_cmp_buf (
         .clk(clk), .rst_n(rst_n), .wr(ch_wr[c]), .wdata(ch_wd[c]),
         .load(load), .act(cmp_act[c])
      );
      pwm_chan_out #(.CNT_W(CNT_W)) u_out (
         .clk(clk), .rst_n(rst_n), .upd(upd), .cnt(count),
         .cmp_act(cmp_act[c]), .inv(ch_inv[c]), .pin(ch_pin[c])
      );
   end
endmodule

// File: rtl/pwm_slice_chk.sv
module pwm_slice_chk #(
   parameter int unsigned CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en,
   input logic             tick,
   input logic             phase_correct,
   input logic             ctr_wr,
   input logic [CNT_W-1:0] ctr_wdata,
   input logic             adv_req,
   input logic             ret_req,
   input logic             irq_clr,
   input logic [CNT_W-1:0] count,
   input logic [CNT_W-1:0] top_act,
   input logic             bnd_step,
   input logic             wrap_pulse,
   input logic             irq_raw,
   input logic             adv_busy,
   input logic             ret_busy
);
   p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !adv_busy && !ctr_wr) |=> $stable(count));

   p_up_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (en && tick && !ret_busy && !ctr_wr && !phase_correct && count < top_act)
      |=> count == $past(count) + CNT_W'(1));

   p_wrap_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_pulse |-> count == '0);

   p_irq_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_raw && !irq_clr) |=> irq_raw);

   p_ret_swallow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_busy && en && tick && !ctr_wr) |=> $stable(count));

   p_ret_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_busy && en && tick && !ctr_wr && !ret_req) |=> !ret_busy);

   p_adv_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_busy && !(en && tick) && !ctr_wr && !adv_req) |=> !adv_busy);

   p_ctr_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ctr_wr |=> count == $past(ctr_wdata));

   p_top_defer_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !bnd_step) |=> $stable(top_act));
endmodule

bind pwm_slice pwm_slice_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .phase_correct(phase_correct),
   .ctr_wr(ctr_wr), .ctr_wdata(ctr_wdata), .adv_req(adv_req), .ret_req(ret_req),
   .irq_clr(irq_clr), .count(count), .top_act(top_act), .bnd_step(bnd_step),
   .wrap_pulse(wrap_pulse), .irq_raw(irq_raw), .adv_busy(adv_busy),
   .ret_busy(ret_busy)
);

// File: tb/sim_pwm_slice.sv
module sim_pwm_slice;
   localparam int unsigned W = 16;

   logic clk = 1'b0, rst_n = 1'b0;
   logic en = 0, tick = 0, pc = 0, inv_a = 0, inv_b = 0;
   logic top_wr = 0, ca_wr = 0, cb_wr = 0, ctr_wr = 0;
   logic [W-1:0] top_wd = 0, ca_wd = 0, cb_wd = 0, ctr_wd = 0;
   logic adv_req = 0, ret_req = 0, irq_clr = 0;
   logic [W-1:0] count;
   logic out_a, out_b, wrap_pulse, irq_raw, adv_busy, ret_busy;

   int checks = 0, errors = 0;
   string scen = "R8";

   // bench model state
   logic [W-1:0] m_cnt, m_top_sh, m_top_act, m_ca_sh, m_ca_act, m_cb_sh, m_cb_act;
   logic m_down, m_la, m_lb, m_advp, m_retp, m_wrap, m_irq;

   always #5 clk = ~clk;

   pwm_slice u0 (
      .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .phase_correct(pc),
      .inv_a(inv_a), .inv_b(inv_b), .top_wr(top_wr), .top_wdata(top_wd),
      .cmp_a_wr(ca_wr), .cmp_a_wdata(ca_wd), .cmp_b_wr(cb_wr), .cmp_b_wdata(cb_wd),
      .ctr_wr(ctr_wr), .ctr_wdata(ctr_wd), .adv_req(adv_req), .ret_req(ret_req),
      .irq_clr(irq_clr), .count(count), .out_a(out_a), .out_b(out_b),
      .wrap_pulse(wrap_pulse), .irq_raw(irq_raw), .adv_busy(adv_busy),
      .ret_busy(ret_busy)
   );

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s (scenario %s) actual=%0h expected=%0h t=%0t", tag, scen, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      m_cnt = 0; m_down = 0; m_top_sh = '1; m_top_act = '1;
      m_ca_sh = 0; m_ca_act = 0; m_cb_sh = 0; m_cb_act = 0;
      m_la = 0; m_lb = 0; m_advp = 0; m_retp = 0; m_wrap = 0; m_irq = 0;
   endtask

   task automatic model_update();
      logic te, mv, bd, nd, adv_do, ret_do;
      logic [W-1:0] nx;
      te = en & tick;
      ret_do = m_retp & te & !ctr_wr;
      adv_do = m_advp & !te & !ctr_wr;
      mv = !ctr_wr && ((te && !m_retp) || adv_do);
      nd = m_down; bd = 0; nx = m_cnt;
      if (!pc) begin
         nd = 0;
         if (m_cnt >= m_top_act) begin nx = 0; bd = 1; end
         else nx = m_cnt + 1;
      end else if (!m_down && m_cnt < m_top_act) begin
         nx = m_cnt + 1;
      end else if (m_cnt == 0) begin
         nx = 0; bd = 1; nd = 0;
      end else begin
         nx = m_cnt - 1;
         bd = (m_cnt == 1);
         nd = (m_cnt != 1);
      end
      if (en || mv) begin
         m_la = (m_cnt < m_ca_act);
         m_lb = (m_cnt < m_cb_act);
      end
      if (!en || (mv && bd)) begin
         m_top_act = m_top_sh; m_ca_act = m_ca_sh; m_cb_act = m_cb_sh;
      end
      if (top_wr) m_top_sh = top_wd;
      if (ca_wr)  m_ca_sh  = ca_wd;
      if (cb_wr)  m_cb_sh  = cb_wd;
      if (ctr_wr) m_cnt = ctr_wd;
      else if (mv) begin m_cnt = nx; m_down = nd; end
      m_wrap = mv & bd;
      m_irq  = (m_irq & !irq_clr) | (mv & bd);
      m_advp = (m_advp & !adv_do) | adv_req;
      m_retp = (m_retp & !ret_do) | ret_req;
   endtask

   task automatic compare();
      check(pc ? "R2" : "R1", 32'(count), 32'(m_cnt));
      check("R3 R7", 32'(out_a), 32'(m_la ^ inv_a));
      check("R3 R7", 32'(out_b), 32'(m_lb ^ inv_b));
      check("R9", 32'(wrap_pulse), 32'(m_wrap));
      check("R9", 32'(irq_raw), 32'(m_irq));
      check("R6", 32'(adv_busy), 32'(m_advp));
      check("R6", 32'(ret_busy), 32'(m_retp));
   endtask

   task automatic step();
      @(posedge clk);
      model_update();
      @(negedge clk);
      compare();
      top_wr = 0; ca_wr = 0; cb_wr = 0; ctr_wr = 0;
      adv_req = 0; ret_req = 0; irq_clr = 0;
   endtask

   task automatic cfg(logic [W-1:0] t, logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] c);
      en = 0; tick = 0;
      top_wr = 1; top_wd = t; ca_wr = 1; ca_wd = a; cb_wr = 1; cb_wd = b;
      ctr_wr = 1; ctr_wd = c;
      step();
      step();
   endtask

   task automatic run(int n, int tick_mod);
      for (int i = 0; i < n; i++) begin
         tick = (tick_mod == 0) ? 1'b1 : ((i % tick_mod) != 0);
         step();
      end
   endtask

   initial begin
      #(200000 * 10);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      model_reset();
      #23 rst_n = 1'b1;
      @(negedge clk);
      // R8: reset state
      scen = "R8";
      check("R8", 32'(count), 0);
      check("R8", 32'(out_a), 0);
      check("R8", 32'(out_b), 0);
      check("R8", 32'({wrap_pulse, irq_raw, adv_busy, ret_busy}), 0);
      // R8: reset limit is all ones: FFFE -> FFFF -> 0 with wrap
      ctr_wr = 1; ctr_wd = 16'hFFFE; step();
      en = 1; run(2, 0);
      check("R8", 32'(count), 0);
      check("R8", 32'(wrap_pulse), 1);

      // R1 R2 R3 sweep
      for (int m = 0; m < 2; m++) begin
         for (int t = 0; t < 4; t++) begin
            for (int a = 0; a <= t + 1; a++) begin
               scen = (m != 0) ? "R2" : "R1";
               pc = (m != 0);
               cfg(W'(t), W'(a), W'(t + 1 - a), 0);
               en = 1;
               run(4 * t + 6, (a % 2 == 0) ? 0 : 3);
            end
         end
      end

      // R4: compare and limit writes while running wait for boundary
      scen = "R4"; pc = 0;
      cfg(5, 2, 4, 0);
      en = 1; run(2, 0);
      ca_wr = 1; ca_wd = 5; top_wr = 1; top_wd = 3; step();
      run(14, 0);
      pc = 1; run(20, 0);

      // R5: halt holds, writes immediate, resume
      scen = "R5"; pc = 0;
      cfg(6, 3, 1, 0);
      en = 1; run(4, 0);
      en = 0; tick = 1; ca_wr = 1; ca_wd = 0; step();
      run(5, 0);
      check("R5", 32'(count), 32'(m_cnt));
      en = 1; run(10, 0);

      // R6: advance while halted, retard while running
      scen = "R6";
      cfg(4, 2, 3, 1);
      adv_req = 1; step();
      run(3, 0);
      check("R6", 32'(count), 2);
      check("R6", 32'(adv_busy), 0);
      en = 1; ret_req = 1; tick = 1; step();
      run(8, 0);
      en = 1; adv_req = 1; run(8, 2);
      ret_req = 1; pc = 1; run(10, 2);

      // R7: polarity
      scen = "R7"; pc = 0;
      cfg(3, 2, 1, 0);
      en = 1; inv_a = 1; run(6, 0);
      inv_b = 1; inv_a = 0; run(6, 0);
      inv_b = 0;

      // R9: sticky interrupt and clear
      scen = "R9";
      irq_clr = 1; step();
      run(3, 0);
      irq_clr = 1; run(4, 0);

      // R10: counter write wins over step, keeps pending requests
      scen = "R10";
      en = 1; ctr_wr = 1; ctr_wd = 2; ret_req = 1; step();
      ctr_wr = 1; ctr_wd = 1; tick = 1; step();
      check("R10", 32'(count), 1);
      run(6, 0);

      // R11: forcing outputs while parked
      scen = "R11";
      cfg(0, 0, 1, 0);
      en = 1; tick = 0; step();
      en = 0; step();
      check("R11", 32'(out_a), 0);
      check("R11", 32'(out_b), 1);
      run(3, 0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule